// File: doc/BRIEF.md
# Serial ADC Standby Controller

This block is the device-side control logic for a serial ADC port that has two data outputs. It oversamples chip select, serial clock and serial data in on the system clock and counts serial-clock falling edges within each frame. It decodes register writes from the opening bits of each frame. At the end of a frame it decides whether the converter enters or leaves a low-power standby state.

While in standby, the two data outputs stop carrying conversion data. They drive ones during a frame and release the bus outside it. Power-down enables go to the internal circuits and, unless retention was requested, to the reference. In that second case the two reference-DAC registers are cleared. Leaving standby needs a long exit frame. After exit, a ready flag stays low until a programmable power-up delay, counted in system-clock cycles, has expired.

The port has no valid/ready stream. Conversion bits from the data path pass straight to the outputs and are never held back. Every other pin is a plain control or status level.

Top module: `sadc_standby_ctrl`

## Requirements
- R1: A frame is a write when its first four serial-data-in bits, sampled on serial-clock falling edges with the first bit as MSB, equal opcode 4'b1000. The next 12 bits, MSB first, are the configuration value. Outside standby, a write with at least 16 falling edges loads `cfg_o` at frame end. A shorter frame, or a frame with another opcode, leaves `cfg_o` unchanged.
- R2: Outside standby, a configuration write with bit 5 set puts the block into standby (`circ_pd_o` high) once chip select has risen at the end of that frame.
- R3: On standby entry, configuration bit 6 = 1 keeps `ref_pd_o` low and keeps both reference-DAC registers. Bit 6 = 0 raises `ref_pd_o` and clears both registers to zero. `ref_pd_o` is never high outside standby.
- R4: In standby, `sdo_a_o` and `sdo_b_o` are 1 while `cs_n_i` is low, and `sdo_oe_o` is low while `cs_n_i` is high. Outside standby, the outputs carry `conv_a_i`/`conv_b_i` and `sdo_oe_o` equals the inverse of `cs_n_i`.
- R5: Standby persists across frames with serial data in held low. During standby, reference-DAC writes and configuration writes that keep bit 5 set have no effect.
- R6: In standby, a configuration write with bit 5 clear leaves standby only if its frame has at least 48 falling edges. With 47 or fewer, the block stays in standby and `cfg_o` is unchanged.
- R7: `ready_o` is low in standby. After exit it rises exactly PU_CYCLES system-clock cycles after `circ_pd_o` falls.
- R8: After exit, `cfg_o` holds the value written in the exit frame, bits 11 to 6 included.
- R9: While `rst_n` is low, the block sets `cfg_o` and both reference-DAC registers to zero, leaves standby, and holds `ready_o` high.
- R10: Outside standby, a frame of at least 16 falling edges with opcode 4'b1001 loads reference-DAC register A. Opcode 4'b1010 loads register B. The 12 bits after the opcode are the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| conv_a_i | input | 1 | Conversion bit for output A |
| conv_b_i | input | 1 | Conversion bit for output B |
| sdo_a_o | output | 1 | Serial data out A |
| sdo_b_o | output | 1 | Serial data out B |
| sdo_oe_o | output | 1 | Output enable for both data outputs |
| cfg_o | output | 12 | Configuration register |
| circ_pd_o | output | 1 | Internal-circuit power-down (standby) |
| ref_pd_o | output | 1 | Reference power-down |
| ready_o | output | 1 | Normal operation may resume |
| refdac_a_o | output | 12 | Reference-DAC register A |
| refdac_b_o | output | 12 | Reference-DAC register B |

## Verification
The checker watches, on every cycle:
- the forced-ones and released-bus behaviour of the outputs in standby;
- that the reference is powered down only within standby, and that entering that state clears both reference-DAC registers;
- that configuration and reference-DAC contents do not move while standby lasts;
- that the ready flag is low during standby and at the moment of exit.

Only the bench's frames can show the rest:
- the opcode decoding and the 16-edge and 48-edge thresholds;
- the exact power-up delay;
- that the exit-frame value is carried across all 64 patterns of the upper configuration bits.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int OP_W     = 4;
  localparam int FIELD_W  = 12;
  localparam int WORD_W   = OP_W + FIELD_W;
  localparam int EDGE_W   = 6;
  localparam int EDGE_MAX = (1 << EDGE_W) - 1;

  localparam logic [OP_W-1:0] OP_CFG  = 4'b1000;
  localparam logic [OP_W-1:0] OP_REFA = 4'b1001;
  localparam logic [OP_W-1:0] OP_REFB = 4'b1010;

  localparam int BIT_STBY   = 5;
  localparam int BIT_REFKEEP = 6;

  typedef struct packed {
    logic [OP_W-1:0]    op;
    logic [FIELD_W-1:0] data;
    logic [EDGE_W-1:0]  edges;
  } frame_t;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= rst_val;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sadc_frame.sv
module sadc_frame
  import sadc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_s,
  input  logic   sclk_s,
  input  logic   sdi_s,
  output logic   frame_end,
  output frame_t frame
);
  logic              cs_q;
  logic              sclk_q;
  logic [EDGE_W-1:0] edge_cnt;
  logic [WORD_W-1:0] shift_q;
  logic              sclk_fall;

  assign sclk_fall = sclk_q & ~sclk_s;
  assign frame_end = cs_s & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sclk_q   <= 1'b0;
      edge_cnt <= '0;
      shift_q  <= '0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
      if (cs_s) begin
        edge_cnt <= '0;
        shift_q  <= '0;
      end else if (sclk_fall) begin
        if (edge_cnt != EDGE_W'(EDGE_MAX)) edge_cnt <= edge_cnt + 1'b1;
        if (edge_cnt < EDGE_W'(WORD_W)) shift_q <= {shift_q[WORD_W-2:0], sdi_s};
      end
    end
  end

  assign frame.op    = shift_q[WORD_W-1 -: OP_W];
  assign frame.data  = shift_q[FIELD_W-1:0];
  assign frame.edges = edge_cnt;
endmodule

// File: rtl/sadc_power.sv
module sadc_power
  import sadc_pkg::*;
#(
  parameter int PU_CYCLES  = 100,
  parameter int EXIT_EDGES = 48,
  parameter int CNT_W      = $clog2(PU_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end,
  input  frame_t             frame,
  output logic [FIELD_W-1:0] cfg,
  output logic [FIELD_W-1:0] refdac_a,
  output logic [FIELD_W-1:0] refdac_b,
  output logic               standby,
  output logic               ref_pd,
  output logic               ready
);
  localparam logic [EDGE_W-1:0] MIN_WR = EDGE_W'(WORD_W);
  localparam logic [EDGE_W-1:0] MIN_EX = EDGE_W'(EXIT_EDGES);

  logic [CNT_W-1:0] pu_cnt;
  logic             full_word;
  logic             long_frame;
  logic             is_cfg;

  assign full_word  = frame.edges >= MIN_WR;
  assign long_frame = frame.edges >= MIN_EX;
  assign is_cfg     = frame.op == OP_CFG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      refdac_a <= '0;
      refdac_b <= '0;
      standby  <= 1'b0;
      pu_cnt   <= '0;
    end else begin
      if (pu_cnt != '0) pu_cnt <= pu_cnt - 1'b1;
      if (frame_end) begin
        if (!standby) begin
          if (full_word) begin
            if (is_cfg) begin
              cfg <= frame.data;
              if (frame.data[BIT_STBY]) begin
                standby <= 1'b1;
                if (!frame.data[BIT_REFKEEP]) begin
                  refdac_a <= '0;
                  refdac_b <= '0;
                end
              end
            end else if (frame.op == OP_REFA) begin
              refdac_a <= frame.data;
            end else if (frame.op == OP_REFB) begin
              refdac_b <= frame.data;
            end
          end
        end else if (is_cfg && long_frame && !frame.data[BIT_STBY]) begin
          cfg     <= frame.data;
          standby <= 1'b0;
          pu_cnt  <= CNT_W'(PU_CYCLES);
        end
      end
    end
  end

  assign ref_pd = standby & ~cfg[BIT_REFKEEP];
  assign ready  = ~standby & (pu_cnt == '0);
endmodule

// File: rtl/sadc_sdo_gate.sv
module sadc_sdo_gate #(
  parameter int LANES = 2
) (
  input  logic             standby,
  input  logic             cs_n,
  input  logic [LANES-1:0] conv,
  output logic [LANES-1:0] sdo,
  output logic             oe
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign sdo[l] = standby ? 1'b1 : conv[l];
  end
  assign oe = ~cs_n;
endmodule

// File: rtl/sadc_standby_ctrl.sv
module sadc_standby_ctrl
  import sadc_pkg::*;
#(
  parameter int PU_CYCLES  = 100,
  parameter int EXIT_EDGES = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n_i,
  input  logic               sclk_i,
  input  logic               sdi_i,
  input  logic               conv_a_i,
  input  logic               conv_b_i,
  output logic               sdo_a_o,
  output logic               sdo_b_o,
  output logic               sdo_oe_o,
  output logic [FIELD_W-1:0] cfg_o,
  output logic               circ_pd_o,
  output logic               ref_pd_o,
  output logic               ready_o,
  output logic [FIELD_W-1:0] refdac_a_o,
  output logic [FIELD_W-1:0] refdac_b_o
);
  logic [2:0] pins_s;
  logic       frame_end;
  frame_t     frame;
  logic       standby;
  logic [1:0] sdo;

  sadc_sync #(.W(3), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_val (3'b100),
    .d       ({cs_n_i, sclk_i, sdi_i}),
    .q       (pins_s)
  );

  sadc_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (pins_s[2]),
    .sclk_s    (pins_s[1]),
    .sdi_s     (pins_s[0]),
    .frame_end (frame_end),
    .frame     (frame)
  );

  sadc_power #(.PU_CYCLES(PU_CYCLES), .EXIT_EDGES(EXIT_EDGES)) u_power (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .frame     (frame),
    .cfg       (cfg_o),
    .refdac_a  (refdac_a_o),
    .refdac_b  (refdac_b_o),
    .standby   (standby),
    .ref_pd    (ref_pd_o),
    .ready     (ready_o)
  );

  sadc_sdo_gate #(.LANES(2)) u_gate (
    .standby (standby),
    .cs_n    (cs_n_i),
    .conv    ({conv_b_i, conv_a_i}),
    .sdo     (sdo),
    .oe      (sdo_oe_o)
  );

  assign sdo_a_o   = sdo[0];
  assign sdo_b_o   = sdo[1];
  assign circ_pd_o = standby;
endmodule

// File: rtl/sadc_standby_chk.sv
module sadc_standby_chk #(
  parameter int FW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n_i,
  input logic          sdo_a_o,
  input logic          sdo_b_o,
  input logic          sdo_oe_o,
  input logic [FW-1:0] cfg_o,
  input logic          circ_pd_o,
  input logic          ref_pd_o,
  input logic          ready_o,
  input logic [FW-1:0] refdac_a_o,
  input logic [FW-1:0] refdac_b_o
);
  AST_STBY_SDO_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    circ_pd_o && !cs_n_i |-> sdo_a_o && sdo_b_o); // R4
  AST_STBY_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    circ_pd_o && cs_n_i |-> !sdo_oe_o); // R4
  AST_REF_PD_IN_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pd_o |-> circ_pd_o); // R3
  AST_REF_PD_CLEARS_DAC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_pd_o) |-> refdac_a_o == '0 && refdac_b_o == '0); // R3
  AST_STBY_DAC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    circ_pd_o && $past(circ_pd_o) |-> $stable(refdac_a_o) && $stable(refdac_b_o)); // R5
  AST_STBY_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    circ_pd_o && $past(circ_pd_o) |-> $stable(cfg_o)); // R5
  AST_NO_READY_IN_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    circ_pd_o |-> !ready_o); // R7
  AST_READY_LOW_AT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(circ_pd_o) |-> !ready_o); // R7
endmodule

bind sadc_standby_ctrl sadc_standby_chk #(.FW(12)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n_i     (cs_n_i),
  .sdo_a_o    (sdo_a_o),
  .sdo_b_o    (sdo_b_o),
  .sdo_oe_o   (sdo_oe_o),
  .cfg_o      (cfg_o),
  .circ_pd_o  (circ_pd_o),
  .ref_pd_o   (ref_pd_o),
  .ready_o    (ready_o),
  .refdac_a_o (refdac_a_o),
  .refdac_b_o (refdac_b_o)
);

// File: tb/sim_sadc_standby_ctrl.sv
`timescale 1ns/1ps
module sim_sadc_standby_ctrl;
  localparam int PU = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, conv_a = 1'b0, conv_b = 1'b0;
  logic sdo_a, sdo_b, sdo_oe, circ_pd, ref_pd, ready;
  logic [11:0] cfg, ref_a, ref_b;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sadc_standby_ctrl #(.PU_CYCLES(PU), .EXIT_EDGES(48)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .conv_a_i(conv_a), .conv_b_i(conv_b), .sdo_a_o(sdo_a), .sdo_b_o(sdo_b),
    .sdo_oe_o(sdo_oe), .cfg_o(cfg), .circ_pd_o(circ_pd), .ref_pd_o(ref_pd),
    .ready_o(ready), .refdac_a_o(ref_a), .refdac_b_o(ref_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [3:0] op, input logic [11:0] val, input int n);
    logic [15:0] w = {op, val};
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    cs_n = 1'b1;
    sdi = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] cur_cfg, ra, rb, ent, ex, val;
    int n;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(cfg == 12'h000, "R9 cfg", cfg, 0);
    chk(circ_pd == 1'b0 && ref_pd == 1'b0, "R9 power", {circ_pd, ref_pd}, 0);
    chk(ready == 1'b1, "R9 ready", ready, 1);
    chk(ref_a == 0 && ref_b == 0, "R9 refdac", {ref_a, ref_b}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: configuration writes with bit 5 clear
    cur_cfg = 12'h000;
    for (int k = 0; k < 24; k++) begin
      val = 12'((k * 331 + 7)) & 12'hFDF;
      frame(4'b1000, val, 16 + (k % 4));
      settle();
      cur_cfg = val;
      chk(cfg == cur_cfg, "R1 write", cfg, cur_cfg);
    end
    frame(4'b1000, 12'h5C3 & 12'hFDF, 15);
    settle();
    chk(cfg == cur_cfg, "R1 short frame", cfg, cur_cfg);
    frame(4'b0011, 12'h0C3, 16);
    settle();
    chk(cfg == cur_cfg, "R1 other opcode", cfg, cur_cfg);

    // R4: normal-mode output path
    for (int p = 0; p < 4; p++) begin
      conv_a = p[0]; conv_b = p[1];
      cs_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(sdo_a == p[0] && sdo_b == p[1] && sdo_oe == 1'b1, "R4 normal pass",
          {sdo_oe, sdo_b, sdo_a}, {1'b1, p[1], p[0]});
      cs_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(sdo_oe == 1'b0, "R4 normal idle", sdo_oe, 0);
    end
    conv_a = 1'b0; conv_b = 1'b0;

    // Main sweep over all 64 patterns of configuration bits 11:6
    for (int v = 0; v < 64; v++) begin
      ra = 12'((v * 37 + 5));
      rb = 12'((v * 91 + 3));
      frame(4'b1001, ra, 16); settle();
      frame(4'b1010, rb, 16); settle();
      chk(ref_a == ra && ref_b == rb, "R10 refdac load", {ref_a, ref_b}, {ra, rb});

      ent = {6'(v), 1'b1, 5'(v)};
      frame(4'b1000, ent, 16); settle();
      chk(circ_pd == 1'b1, "R2 enter", circ_pd, 1);
      chk(ref_pd == !ent[6], "R3 ref_pd", ref_pd, !ent[6]);
      chk(ref_a == (ent[6] ? ra : 12'h0) && ref_b == (ent[6] ? rb : 12'h0),
          "R3 refdac retain", {ref_a, ref_b}, ent[6] ? {ra, rb} : 24'h0);
      chk(ready == 1'b0, "R7 ready in standby", ready, 0);

      if (v % 8 == 0) begin
        frame(4'b0000, 12'h000, 24); settle();
        chk(circ_pd == 1'b1, "R5 sdi low frame", circ_pd, 1);
        frame(4'b1001, ~ra, 16); settle();
        chk(ref_a == (ent[6] ? ra : 12'h0), "R5 refdac ignored", ref_a, ent[6] ? ra : 12'h0);
        frame(4'b1000, 12'hFFF, 20); settle();
        chk(cfg == ent && circ_pd == 1'b1, "R5 cfg ignored", cfg, ent);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(sdo_a && sdo_b && sdo_oe, "R4 standby ones", {sdo_oe, sdo_b, sdo_a}, 7);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sdo_oe == 1'b0, "R4 standby released", sdo_oe, 0);
      end

      ex = {~6'(v), 1'b0, 5'(v + 1)};
      if (v % 8 == 3) begin
        frame(4'b1000, ex, 47); settle();
        chk(circ_pd == 1'b1 && cfg == ent, "R6 47 edges", cfg, ent);
      end
      frame(4'b1000, ex, 48);
      n = 0;
      while (circ_pd && n < 30) begin @(negedge clk); n++; end
      chk(circ_pd == 1'b0, "R6 exit at 48", circ_pd, 0);
      n = 0;
      while (!ready && n < 4 * PU) begin @(negedge clk); n++; end
      chk(n == PU, "R7 power-up delay", n, PU);
      chk(cfg == ex, "R8 exit cfg", cfg, ex);
    end

    // R6: edge-count sweep of exit frames around the threshold
    frame(4'b1000, 12'h060, 16); settle();
    for (int e = 16; e <= 52; e += 4) begin
      frame(4'b1000, 12'h0C0, e); settle();
      if (e < 48) chk(circ_pd == 1'b1 && cfg == 12'h060, "R6 short exit", cfg, 12'h060);
      else chk(circ_pd == 1'b0 && cfg == 12'h0C0, "R6 long exit", cfg, 12'h0C0);
      if (!circ_pd) begin
        repeat (PU + 2) @(negedge clk);
        frame(4'b1000, 12'h060, 16); settle();
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule